// File: doc/BRIEF.md
# Small-Sector Write-Back Cache over Large Erase Blocks

This block lets a host treat a flash device as an array of small logical sectors although the device can only erase in much larger blocks. One erase block at a time lives in an on-chip byte buffer, described by a block tag and three flags: valid, dirty, and erased. The erased flag means the backing block in flash has already been wiped and holds none of the buffered data. Host writes and sector erases change the buffer. Whenever the backing block still holds old data, the block erases it once. The whole buffered block is programmed back page by page when another block is needed and at the end of each write or erase request. Host reads bypass the buffer and go straight to flash.

Sizes are parameters. A logical sector is `2**SECT_SHIFT` bytes, an erase block is `2**BLK_SHIFT` bytes, and a program page is `2**PAGE_SHIFT` bytes. The defaults are small (16-byte sectors, 128-byte blocks, 32-byte pages) so that simulation stays short. The same ratio of 8 sectors per block holds for 512-byte sectors over 4 KiB blocks. Below the block sits a command sequencer, outside this project, that runs read, block-erase and page-program commands. Each command is a one-cycle `cmd_req` pulse, and the sequencer answers with a one-cycle `cmd_done`. While it runs a command it streams read bytes in, or pulls program bytes out.

Top module: `sector_cache`

## Requirements
- R1: After reset the buffer holds no block: `req_ready` is 1, `cmd_req` and `req_done` are 0. The first write or erase request to any block therefore reads that block in.
- R2: A sector `s` maps to erase block `s >> (BLK_SHIFT-SECT_SHIFT)` and to slot `s mod 2**(BLK_SHIFT-SECT_SHIFT)` inside it. Fill and erase commands carry the block's byte address (`block << BLK_SHIFT`), and the final flash image matches sector-by-sector writes.
- R3: A sector whose block equals the tag while valid is set is a hit and issues no read. Otherwise it is a miss, and one read command (cmd_op 0) of `2**BLK_SHIFT` bytes refills the whole buffer.
- R4: On a miss with dirty or erased set, the buffer is flushed before the refill; with both clear no program is issued. After a refill, valid is set and dirty and erased are clear.
- R5: A flush issues `2**(BLK_SHIFT-PAGE_SHIFT)` program commands (cmd_op 2), each of `2**PAGE_SHIFT` bytes at ascending page addresses, only while dirty or erased is set, and then clears both flags.
- R6: For a write (req_op 1), if erased is clear one block-erase command (cmd_op 1) is issued and erased is set. Then one sector of host bytes from the `wr_*` stream is copied into the slot, and dirty is set.
- R7: For a sector erase (req_op 2 or 3), the same erase-if-needed step is taken. The slot is then filled with 0xFF and dirty is set.
- R8: Each write or erase request ends with a flush. `req_done` pulses only after the last program completes, so flash then holds the written data.
- R9: A read (req_op 0) issues one read command of `count << SECT_SHIFT` bytes at `sector << SECT_SHIFT` and forwards the bytes in order on `rd_*`. It leaves the tag and flags untouched, so a later write to the buffered block still hits.
- R10: Requests are taken one at a time: `req_ready` is 1 only when idle, and `req_done` pulses once per request. A request with count 0 completes with no command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Host request strobe |
| req_ready | output | 1 | Block is idle and takes a request |
| req_op | input | 2 | 0 read, 1 write, 2 or 3 sector erase |
| req_sector | input | ADDR_W-SECT_SHIFT | First logical sector |
| req_count | input | CNT_W | Number of sectors |
| req_done | output | 1 | One-cycle pulse when the request is finished |
| wr_valid | input | 1 | Host write byte valid |
| wr_ready | output | 1 | Block takes a write byte |
| wr_data | input | 8 | Host write byte |
| rd_valid | output | 1 | Read byte valid |
| rd_data | output | 8 | Read byte |
| cmd_req | output | 1 | One-cycle command pulse to the sequencer |
| cmd_op | output | 2 | 0 read, 1 block erase, 2 page program |
| cmd_addr | output | ADDR_W | Command byte address |
| cmd_len | output | LEN_W | Command byte count |
| cmd_done | input | 1 | Sequencer finished the command |
| lo_rvalid | input | 1 | Byte read from flash valid |
| lo_rdata | input | 8 | Byte read from flash |
| lo_wtake | input | 1 | Sequencer takes one program byte |
| lo_wdata | output | 8 | Program byte at the current buffer pointer |

## Verification
The flash model programs by AND-ing bits into an image that does not start erased. A design that skipped the erase-if-needed step, or erased the wrong block, therefore leaves corrupt bytes that the read-back against the reference array exposes.

Per-request counts of read, erase and program commands catch each of these faults:
- a lost hit after a bypass read, which shows up as an extra refill;
- a flush on a clean miss, which shows up as extra programs;
- a second erase inside one request;
- a missing final flush.

Requests that cross block boundaries, a write stream with gaps in `wr_valid`, and a zero-count request cover the remaining corners.

// File: rtl/scache_pkg.sv
`timescale 1ns/1ps
// Shared encodings for the small-sector cache.
package scache_pkg;
    // Commands sent to the lower sequencer.
    typedef enum logic [1:0] {
        LO_READ  = 2'd0,
        LO_ERASE = 2'd1,
        LO_PROG  = 2'd2
    } lo_op_e;
endpackage

// File: rtl/scache_buf.sv
`timescale 1ns/1ps
// Erase-block byte buffer: one write port, one asynchronous read port.
// Assumes: the contents need no reset; the flags say what is meaningful.
module scache_buf #(
    parameter int BLK_SHIFT = 7
) (
    input  logic                 clk,
    input  logic                 we,
    input  logic [BLK_SHIFT-1:0] waddr,
    input  logic [7:0]           wdata,
    input  logic [BLK_SHIFT-1:0] raddr,
    output logic [7:0]           rdata
);
    localparam int BYTES = 1 << BLK_SHIFT;

    logic [7:0] mem [BYTES];

    // Store one byte per cycle.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/scache_flags.sv
`timescale 1ns/1ps
// Tag and state flags of the buffered erase block.
// Assumes: a fill request overrides every other update in the same cycle.
module scache_flags #(
    parameter int TAG_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fill_set,
    input  logic [TAG_W-1:0] fill_tag,
    input  logic             erase_set,
    input  logic             dirty_set,
    input  logic             flush_clr,
    output logic             valid,
    output logic             dirty,
    output logic             erased,
    output logic [TAG_W-1:0] tag
);
    // Update flags from the controller's one-cycle events.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid  <= 1'b0;
            dirty  <= 1'b0;
            erased <= 1'b0;
            tag    <= '0;
        end else if (fill_set) begin
            valid  <= 1'b1;
            dirty  <= 1'b0;
            erased <= 1'b0;
            tag    <= fill_tag;
        end else begin
            if (flush_clr) begin
                dirty  <= 1'b0;
                erased <= 1'b0;
            end
            if (erase_set) erased <= 1'b1;
            if (dirty_set) dirty  <= 1'b1;
        end
    end

    assert_fill_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fill_set |=> (valid && !dirty && !erased && tag == $past(fill_tag)));
    assert_flush_R5: assert property (@(posedge clk) disable iff (!rst_n)
        flush_clr |=> (!dirty && !erased));
    assert_keep_R3: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> valid);
endmodule

// File: rtl/scache_ctrl.sv
`timescale 1ns/1ps
// Request sequencer: lookup, flush, fill, erase-if-needed, sector copy,
// final flush, and the bypass read path.
// Assumes: the lower sequencer answers each cmd_req with exactly one
// cmd_done, and never raises lo_wtake or lo_rvalid in the cmd_done cycle.
module scache_ctrl
    import scache_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int SECT_SHIFT = 4,
    parameter int BLK_SHIFT  = 7,
    parameter int PAGE_SHIFT = 5,
    parameter int CNT_W      = 6,
    parameter int LEN_W      = 11
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req_valid,
    output logic                       req_ready,
    input  logic [1:0]                 req_op,
    input  logic [ADDR_W-SECT_SHIFT-1:0] req_sector,
    input  logic [CNT_W-1:0]           req_count,
    output logic                       req_done,
    input  logic                       wr_valid,
    output logic                       wr_ready,
    input  logic [7:0]                 wr_data,
    output logic                       rd_valid,
    output logic [7:0]                 rd_data,
    output logic                       cmd_req,
    output logic [1:0]                 cmd_op,
    output logic [ADDR_W-1:0]          cmd_addr,
    output logic [LEN_W-1:0]           cmd_len,
    input  logic                       cmd_done,
    input  logic                       lo_rvalid,
    input  logic [7:0]                 lo_rdata,
    input  logic                       lo_wtake,
    output logic                       buf_we,
    output logic [BLK_SHIFT-1:0]       buf_waddr,
    output logic [7:0]                 buf_wdata,
    output logic [BLK_SHIFT-1:0]       buf_raddr,
    input  logic                       fl_valid,
    input  logic                       fl_dirty,
    input  logic                       fl_erased,
    input  logic [ADDR_W-BLK_SHIFT-1:0] fl_tag,
    output logic                       fl_fill,
    output logic [ADDR_W-BLK_SHIFT-1:0] fl_new_tag,
    output logic                       fl_erase_set,
    output logic                       fl_dirty_set,
    output logic                       fl_clear
);
    localparam int SPB        = BLK_SHIFT - SECT_SHIFT;
    localparam int SEC_W      = ADDR_W - SECT_SHIFT;
    localparam int TAG_W      = ADDR_W - BLK_SHIFT;
    localparam int BLK_BYTES  = 1 << BLK_SHIFT;
    localparam int PAGE_BYTES = 1 << PAGE_SHIFT;

    typedef enum logic [3:0] {
        S_IDLE, S_LOOK, S_FLUSH_CMD, S_FLUSH_WAIT, S_FILL_CMD, S_FILL_WAIT,
        S_PREP, S_ERASE_CMD, S_ERASE_WAIT, S_COPY, S_NEXT,
        S_RD_CMD, S_RD_WAIT, S_DONE
    } state_e;

    state_e                state;
    logic [1:0]            op_q;
    logic [SEC_W-1:0]      sec_q;
    logic [CNT_W-1:0]      cnt_q;
    logic [BLK_SHIFT-1:0]  ptr;
    logic                  fl_final;

    logic [TAG_W-1:0]      blk;
    logic [SPB-1:0]        slot;
    logic                  hit;
    logic                  is_write;
    logic                  copy_step;
    logic                  sect_last;

    assign blk       = sec_q[SEC_W-1:SPB];
    assign slot      = sec_q[SPB-1:0];
    assign hit       = fl_valid && (fl_tag == blk);
    assign is_write  = (op_q == 2'd1);
    assign copy_step = (state == S_COPY) && (op_q[1] || wr_valid);
    assign sect_last = &ptr[SECT_SHIFT-1:0];

    // Main sequencer: state, request fields and byte pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            op_q     <= 2'd0;
            sec_q    <= '0;
            cnt_q    <= '0;
            ptr      <= '0;
            fl_final <= 1'b0;
        end else begin
            case (state)
                S_IDLE: if (req_valid) begin
                    op_q  <= req_op;
                    sec_q <= req_sector;
                    cnt_q <= req_count;
                    if (req_count == '0)      state <= S_DONE;
                    else if (req_op == 2'd0)  state <= S_RD_CMD;
                    else                      state <= S_LOOK;
                end
                S_LOOK: begin
                    ptr <= '0;
                    if (hit) state <= S_PREP;
                    else if (fl_dirty || fl_erased) begin
                        fl_final <= 1'b0;
                        state    <= S_FLUSH_CMD;
                    end else state <= S_FILL_CMD;
                end
                S_FLUSH_CMD: state <= S_FLUSH_WAIT;
                S_FLUSH_WAIT: begin
                    if (lo_wtake) ptr <= ptr + BLK_SHIFT'(1);
                    if (cmd_done) begin
                        if (ptr != '0)     state <= S_FLUSH_CMD;
                        else if (fl_final) state <= S_DONE;
                        else               state <= S_FILL_CMD;
                    end
                end
                S_FILL_CMD: begin
                    ptr   <= '0;
                    state <= S_FILL_WAIT;
                end
                S_FILL_WAIT: begin
                    if (lo_rvalid) ptr <= ptr + BLK_SHIFT'(1);
                    if (cmd_done)  state <= S_PREP;
                end
                S_PREP: begin
                    ptr   <= '0;
                    state <= fl_erased ? S_COPY : S_ERASE_CMD;
                end
                S_ERASE_CMD: state <= S_ERASE_WAIT;
                S_ERASE_WAIT: if (cmd_done) state <= S_COPY;
                S_COPY: if (copy_step) begin
                    ptr <= ptr + BLK_SHIFT'(1);
                    if (sect_last) state <= S_NEXT;
                end
                S_NEXT: begin
                    ptr <= '0;
                    if (cnt_q == CNT_W'(1)) begin
                        if (fl_dirty || fl_erased) begin
                            fl_final <= 1'b1;
                            state    <= S_FLUSH_CMD;
                        end else state <= S_DONE;
                    end else begin
                        sec_q <= sec_q + SEC_W'(1);
                        cnt_q <= cnt_q - CNT_W'(1);
                        state <= S_LOOK;
                    end
                end
                S_RD_CMD: state <= S_RD_WAIT;
                S_RD_WAIT: if (cmd_done) state <= S_DONE;
                S_DONE: state <= S_IDLE;
                default: state <= S_IDLE;
            endcase
        end
    end

    // Command fields for the lower sequencer, one-cycle pulse per command.
    always_comb begin
        cmd_req  = 1'b0;
        cmd_op   = LO_READ;
        cmd_addr = '0;
        cmd_len  = '0;
        case (state)
            S_FLUSH_CMD: begin
                cmd_req  = 1'b1;
                cmd_op   = LO_PROG;
                cmd_addr = {fl_tag, ptr};
                cmd_len  = LEN_W'(PAGE_BYTES);
            end
            S_FILL_CMD: begin
                cmd_req  = 1'b1;
                cmd_addr = {blk, {BLK_SHIFT{1'b0}}};
                cmd_len  = LEN_W'(BLK_BYTES);
            end
            S_ERASE_CMD: begin
                cmd_req  = 1'b1;
                cmd_op   = LO_ERASE;
                cmd_addr = {blk, {BLK_SHIFT{1'b0}}};
                cmd_len  = LEN_W'(BLK_BYTES);
            end
            S_RD_CMD: begin
                cmd_req  = 1'b1;
                cmd_addr = {sec_q, {SECT_SHIFT{1'b0}}};
                cmd_len  = LEN_W'(cnt_q) << SECT_SHIFT;
            end
            default: ;
        endcase
    end

    // Buffer write source: refill bytes, host bytes or erased pattern.
    always_comb begin
        buf_we    = 1'b0;
        buf_waddr = ptr;
        buf_wdata = lo_rdata;
        if (state == S_FILL_WAIT && lo_rvalid) begin
            buf_we = 1'b1;
        end else if (copy_step) begin
            buf_we    = 1'b1;
            buf_waddr = {slot, ptr[SECT_SHIFT-1:0]};
            buf_wdata = op_q[1] ? 8'hFF : wr_data;
        end
    end

    assign buf_raddr    = ptr;
    assign req_ready    = (state == S_IDLE);
    assign req_done     = (state == S_DONE);
    assign wr_ready     = (state == S_COPY) && is_write;
    assign rd_valid     = (state == S_RD_WAIT) && lo_rvalid;
    assign rd_data      = lo_rdata;
    assign fl_fill      = (state == S_FILL_WAIT) && cmd_done;
    assign fl_new_tag   = blk;
    assign fl_erase_set = (state == S_ERASE_WAIT) && cmd_done;
    assign fl_dirty_set = copy_step && sect_last;
    assign fl_clear     = (state == S_FLUSH_WAIT) && cmd_done && (ptr == '0);

    assert_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_req |=> !cmd_req);
    assert_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        req_done |=> req_ready);
    assert_prog_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_req && cmd_op == LO_PROG) |-> (fl_dirty || fl_erased));
    assert_erase_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_req && cmd_op == LO_ERASE) |-> !fl_erased);
    assert_miss_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_FILL_CMD) |-> !(fl_valid && fl_tag == blk));
    assert_bypass_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_RD_WAIT) |=> ($stable(fl_tag) && $stable(fl_valid)));
endmodule

// File: rtl/sector_cache.sv
`timescale 1ns/1ps
// Small-sector cache: presents flash as small erasable sectors on top of
// large erase blocks, using one buffered erase block with write-back.
// Assumes: SECT_SHIFT < BLK_SHIFT, PAGE_SHIFT <= BLK_SHIFT.
module sector_cache #(
    parameter int ADDR_W     = 16,
    parameter int SECT_SHIFT = 4,
    parameter int BLK_SHIFT  = 7,
    parameter int PAGE_SHIFT = 5,
    parameter int CNT_W      = 6,
    localparam int SEC_W     = ADDR_W - SECT_SHIFT,
    localparam int LEN_W     = (CNT_W + SECT_SHIFT > BLK_SHIFT) ?
                               CNT_W + SECT_SHIFT + 1 : BLK_SHIFT + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_op,
    input  logic [SEC_W-1:0]  req_sector,
    input  logic [CNT_W-1:0]  req_count,
    output logic              req_done,
    input  logic              wr_valid,
    output logic              wr_ready,
    input  logic [7:0]        wr_data,
    output logic              rd_valid,
    output logic [7:0]        rd_data,
    output logic              cmd_req,
    output logic [1:0]        cmd_op,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [LEN_W-1:0]  cmd_len,
    input  logic              cmd_done,
    input  logic              lo_rvalid,
    input  logic [7:0]        lo_rdata,
    input  logic              lo_wtake,
    output logic [7:0]        lo_wdata
);
    localparam int TAG_W = ADDR_W - BLK_SHIFT;

    logic                 buf_we;
    logic [BLK_SHIFT-1:0] buf_waddr;
    logic [7:0]           buf_wdata;
    logic [BLK_SHIFT-1:0] buf_raddr;
    logic                 fl_valid;
    logic                 fl_dirty;
    logic                 fl_erased;
    logic [TAG_W-1:0]     fl_tag;
    logic                 fl_fill;
    logic [TAG_W-1:0]     fl_new_tag;
    logic                 fl_erase_set;
    logic                 fl_dirty_set;
    logic                 fl_clear;

    scache_ctrl #(
        .ADDR_W(ADDR_W), .SECT_SHIFT(SECT_SHIFT), .BLK_SHIFT(BLK_SHIFT),
        .PAGE_SHIFT(PAGE_SHIFT), .CNT_W(CNT_W), .LEN_W(LEN_W)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
        .req_sector(req_sector), .req_count(req_count), .req_done(req_done),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
        .rd_valid(rd_valid), .rd_data(rd_data),
        .cmd_req(cmd_req), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
        .cmd_len(cmd_len), .cmd_done(cmd_done),
        .lo_rvalid(lo_rvalid), .lo_rdata(lo_rdata), .lo_wtake(lo_wtake),
        .buf_we(buf_we), .buf_waddr(buf_waddr), .buf_wdata(buf_wdata),
        .buf_raddr(buf_raddr),
        .fl_valid(fl_valid), .fl_dirty(fl_dirty), .fl_erased(fl_erased),
        .fl_tag(fl_tag), .fl_fill(fl_fill), .fl_new_tag(fl_new_tag),
        .fl_erase_set(fl_erase_set), .fl_dirty_set(fl_dirty_set),
        .fl_clear(fl_clear)
    );

    scache_flags #(.TAG_W(TAG_W)) u_flags (
        .clk(clk), .rst_n(rst_n),
        .fill_set(fl_fill), .fill_tag(fl_new_tag),
        .erase_set(fl_erase_set), .dirty_set(fl_dirty_set),
        .flush_clr(fl_clear),
        .valid(fl_valid), .dirty(fl_dirty), .erased(fl_erased), .tag(fl_tag)
    );

    scache_buf #(.BLK_SHIFT(BLK_SHIFT)) u_buf (
        .clk(clk), .we(buf_we), .waddr(buf_waddr), .wdata(buf_wdata),
        .raddr(buf_raddr), .rdata(lo_wdata)
    );
endmodule

// File: tb/sector_cache_tb.sv
`timescale 1ns/1ps
module sector_cache_tb;
    localparam int SB    = 16;
    localparam int BB    = 128;
    localparam int PB    = 32;
    localparam int NPG   = BB / PB;
    localparam int FSIZE = 4096;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_op = 2'd0;
    logic [11:0] req_sector = '0;
    logic [5:0]  req_count = '0;
    logic        req_done;
    logic        wr_valid = 1'b0;
    logic        wr_ready;
    logic [7:0]  wr_data = 8'h00;
    logic        rd_valid;
    logic [7:0]  rd_data;
    logic        cmd_req;
    logic [1:0]  cmd_op;
    logic [15:0] cmd_addr;
    logic [10:0] cmd_len;
    logic        cmd_done = 1'b0;
    logic        lo_rvalid = 1'b0;
    logic [7:0]  lo_rdata = 8'h00;
    logic        lo_wtake = 1'b0;
    logic [7:0]  lo_wdata;

    sector_cache u_dut (.*);

    always #10 clk = ~clk;

    logic [7:0] flash [FSIZE];
    logic [7:0] refm  [FSIZE];
    logic [7:0] expq [$];
    logic [7:0] wq [$];
    int total = 0;
    int bad = 0;
    int n_rd = 0, n_er = 0, n_pg = 0;
    int gap = 0;

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Lower sequencer model: flash programs by AND-ing bits.
    initial begin
        forever begin
            @(negedge clk);
            cmd_done  = 1'b0;
            lo_rvalid = 1'b0;
            lo_wtake  = 1'b0;
            if (cmd_req) begin
                int a, n;
                logic [1:0] o;
                a = int'(cmd_addr); n = int'(cmd_len); o = cmd_op;
                if (o == 2'd0) begin
                    for (int i = 0; i < n; i++) begin
                        @(negedge clk);
                        lo_rvalid = 1'b1;
                        lo_rdata  = flash[(a + i) % FSIZE];
                    end
                    @(negedge clk);
                    lo_rvalid = 1'b0;
                end else if (o == 2'd2) begin
                    for (int i = 0; i < n; i++) begin
                        @(negedge clk);
                        lo_wtake = 1'b1;
                        #1 flash[(a + i) % FSIZE] = flash[(a + i) % FSIZE] & lo_wdata;
                    end
                    @(negedge clk);
                    lo_wtake = 1'b0;
                end else begin
                    repeat (3) @(negedge clk);
                    for (int i = 0; i < BB; i++) flash[((a / BB) * BB + i) % FSIZE] = 8'hFF;
                end
                cmd_done = 1'b1;
            end
        end
    end

    // Per-cycle monitor: command counts and read data against the model.
    initial begin
        forever begin
            @(negedge clk); #2;
            if (rst_n && cmd_req) begin
                if (cmd_op == 2'd0) n_rd++;
                else if (cmd_op == 2'd1) n_er++;
                else n_pg++;
            end
            if (rst_n && rd_valid) begin
                if (expq.size() == 0) chk("R9 unexpected read byte", 1, 0);
                else chk("R9 read data", int'(rd_data), int'(expq.pop_front()));
            end
        end
    end

    task automatic run_req(input int op, input int sec, input int cnt, input int seed,
                           input int e_rd, input int e_er, input int e_pg, input string tag);
        n_rd = 0; n_er = 0; n_pg = 0;
        for (int s = 0; s < cnt; s++)
            for (int b = 0; b < SB; b++) begin
                int ad;
                ad = (sec + s) * SB + b;
                if (op == 1) begin
                    refm[ad] = 8'((seed + ad * 13) & 8'hFF);
                    wq.push_back(refm[ad]);
                end else if (op == 2) refm[ad] = 8'hFF;
                else expq.push_back(refm[ad]);
            end
        @(negedge clk);
        req_valid = 1'b1; req_op = 2'(op); req_sector = 12'(sec); req_count = 6'(cnt);
        @(negedge clk);
        req_valid = 1'b0;
        forever begin
            if (req_done) break;
            gap++;
            if (wr_ready && wq.size() > 0 && (gap % 5 != 4)) begin
                wr_valid = 1'b1;
                wr_data  = wq.pop_front();
            end else wr_valid = 1'b0;
            @(negedge clk);
        end
        wr_valid = 1'b0;
        @(negedge clk); #3;
        chk({tag, " read cmds"}, n_rd, e_rd);
        chk({tag, " erase cmds"}, n_er, e_er);
        chk({tag, " program cmds"}, n_pg, e_pg);
        chk({tag, " host bytes left"}, wq.size() + expq.size(), 0);
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #(20ns * 150000);
        bad++; total++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < FSIZE; i++) begin
            flash[i] = 8'((i * 7 + 3) & 8'hFF);
            refm[i]  = flash[i];
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #3;
        chk("R1 reset req_ready", int'(req_ready), 1);
        chk("R1 reset cmd_req", int'(cmd_req), 0);
        chk("R1 reset req_done", int'(req_done), 0);
        chk("R10 reset rd_valid", int'(rd_valid), 0);

        run_req(0, 2, 3, 0, 1, 0, 0, "R9 plain read");
        run_req(1, 9, 1, 5, 1, 1, NPG, "R1 R6 first write fills");
        run_req(1, 10, 1, 9, 0, 1, NPG, "R3 hit write");
        run_req(2, 15, 2, 0, 1, 2, 2 * NPG, "R4 R7 erase across blocks");
        run_req(0, 8, 10, 0, 1, 0, 0, "R7 read erased data");
        run_req(1, 20, 3, 17, 0, 1, NPG, "R6 multi write one erase");
        run_req(0, 20, 3, 0, 1, 0, 0, "R8 read back write");
        run_req(1, 23, 1, 33, 0, 1, NPG, "R9 hit after bypass read");
        run_req(2, 0, 1, 0, 1, 1, NPG, "R4 clean miss no flush");
        run_req(1, 7, 2, 71, 1, 2, 2 * NPG, "R5 R8 write across blocks");
        run_req(1, 5, 0, 0, 0, 0, 0, "R10 zero count");
        run_req(0, 0, 24, 0, 1, 0, 0, "R2 full read back");
        for (int i = 0; i < 24 * SB; i++)
            if (flash[i] != refm[i]) chk("R2 flash image byte", int'(flash[i]), int'(refm[i]));
        chk("R2 flash image compared", 1, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule